// File: doc/BRIEF.md
# Oversampled Pulse-Width Serial Receiver

This block recovers a fixed-length word from a single-wire line that carries pulse-width coded bits. The line rests high. Each bit lasts 16 clock periods, and each bit starts by pulling the line low. A short low pulse codes a one and a long low pulse codes a zero. The receiver runs at 16 times the bit rate. It passes the line through a two-stage synchroniser and restarts its bit timing on every falling edge. It reads the line at a fixed offset after that edge. Because it does not clock a shift register at the nominal bit rate, it tolerates phase drift between sender and receiver.

A host pulses `arm` when it expects a response. The receiver then collects the data bits, most significant first. It waits for the falling edge of the trailing stop bit and then delivers the word with a one-cycle `valid` strobe. The line may stay quiet for too long while bits are still expected. In that case the receiver abandons the word, raises `timeout_err` and returns to idle.

Top module: `pw_line_rx`

## Requirements
- R1: After reset, `data_out` is all zeros and both `valid` and `timeout_err` are low.
- R2: The receiver reads the synchronised line SAMPLE_OFS (default 5) cycles after each detected falling edge. High at that instant gives a 1 and low gives a 0. With 16-cycle bit frames, a frame low for its first 4 cycles decodes as 1, and a frame low for its first 12 cycles decodes as 0.
- R3: Bits arrive most significant first. The first bit received after arming ends up in `data_out[NBITS-1]` and the last data bit ends up in `data_out[0]`.
- R4: `valid` is high for exactly one cycle. It pulses when the falling edge of the bit that follows the NBITS data bits (the stop bit) is detected. `data_out` takes the new word on that same edge and keeps it until the next `valid`.
- R5: Falling edges that occur between a frame's starting edge and its sample point are ignored. A frame with cycles 0-1 low, 2-3 high, 4-6 low and 7-15 high decodes as 0.
- R6: If no falling edge is seen within TIMEOUT (default 64) cycles while a bit or the stop edge is still expected, the receiver drops the word and sets `timeout_err`. In that case `valid` does not pulse and `data_out` is left unchanged.
- R7: Arming in idle clears `timeout_err`. `arm` has no effect while a word is in progress.
- R8: Line activity while the receiver is not armed produces no `valid` and does not change `data_out`.
- R9: The stop bit's value is not stored. The word is the same whether the stop frame codes a 1 or a 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, 16 per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Raw asynchronous serial line, idle high |
| arm | input | 1 | Start collecting one response |
| data_out | output | NBITS | Last complete word, MSB received first |
| valid | output | 1 | One-cycle strobe when a word completes |
| timeout_err | output | 1 | Set on abort, cleared by the next arm |

## Verification
Six words are sent through the normal frame shape: all zeros, all ones, two alternating patterns, a pattern with only the end bits set, and a mixed word. Between them they separate decode errors from bit-order errors and from shift-alignment errors. Directed cases then send a glitched frame that decodes one way if edges inside the sample window are ignored and the other way if they are honoured. They also cut a word short to force the timeout, pulse `arm` in the middle of a word, drive full traffic while unarmed, and send a stop frame coded as zero.

// File: rtl/pw_line_rx.sv
`timescale 1ns/1ps
module pw_line_rx #(
  parameter int NBITS      = 32,
  parameter int SAMPLE_OFS = 5,
  parameter int TIMEOUT    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic             arm,
  output logic [NBITS-1:0] data_out,
  output logic             valid,
  output logic             timeout_err
);
  localparam int BW = $clog2(NBITS + 1);
  localparam int OW = $clog2(SAMPLE_OFS + 1);
  localparam int TW = $clog2(TIMEOUT);
  localparam logic [1:0] S_IDLE = 2'd0, S_WAIT = 2'd1, S_SAMP = 2'd2;

  logic             s1, s2, s3;
  logic [1:0]       st;
  logic [BW-1:0]    nbit;
  logic [OW-1:0]    ofs;
  logic [TW-1:0]    tmr;
  logic [NBITS-1:0] shreg;

  wire fall   = s3 & ~s2;
  wire last   = (nbit == BW'(NBITS));
  wire expire = (tmr == TW'(TIMEOUT - 1));
  wire at_pt  = (ofs == OW'(SAMPLE_OFS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= line_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      nbit        <= '0;
      ofs         <= '0;
      tmr         <= '0;
      shreg       <= '0;
      data_out    <= '0;
      valid       <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        S_IDLE: if (arm) begin
          st          <= S_WAIT;
          nbit        <= '0;
          tmr         <= '0;
          timeout_err <= 1'b0;
        end
        S_WAIT: begin
          if (fall) begin
            if (last) begin
              valid    <= 1'b1;
              data_out <= shreg;
              st       <= S_IDLE;
            end else begin
              ofs <= OW'(1);
              st  <= S_SAMP;
            end
          end else if (expire) begin
            timeout_err <= 1'b1;
            st          <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_SAMP: begin
          if (at_pt) begin
            shreg <= {shreg[NBITS-2:0], s2};
            nbit  <= nbit + 1'b1;
            tmr   <= '0;
            st    <= S_WAIT;
          end else begin
            ofs <= ofs + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_line_rx_chk.sv
`timescale 1ns/1ps
module pw_line_rx_chk #(
  parameter int NBITS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             valid,
  input logic             timeout_err,
  input logic [NBITS-1:0] data_out,
  input logic [1:0]       st
);
  localparam logic [1:0] C_IDLE = 2'd0, C_WAIT = 2'd1;

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(data_out));

  p_valid_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($past(st) == C_WAIT));

  p_err_from_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> ($past(st) == C_WAIT));

  p_no_valid_on_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && timeout_err));

  p_arm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && st == C_IDLE) |=> (!timeout_err && st == C_WAIT));
endmodule

bind pw_line_rx pw_line_rx_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .valid(valid),
  .timeout_err(timeout_err), .data_out(data_out), .st(st)
);

// File: tb/sim_pw_line_rx.sv
`timescale 1ns/1ps
module sim_pw_line_rx;
  localparam logic [15:0] F_ONE = 16'hFFF0;
  localparam logic [15:0] F_ZERO = 16'hF000;
  localparam logic [15:0] F_GLITCH = 16'hFF8C;
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hAAAA_AAAA,
                                       32'h5555_5555, 32'h8000_0001, 32'h1234_5678};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b1;
  logic arm = 1'b0;
  logic [31:0] data_out;
  logic valid, timeout_err;
  int n_chk = 0, n_fail = 0, vcnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pw_line_rx u0 (.clk(clk), .rst_n(rst_n), .line_in(line_in), .arm(arm),
                 .data_out(data_out), .valid(valid), .timeout_err(timeout_err));

  always @(negedge clk) if (valid) vcnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] pat, input bit poke);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      line_in = pat[i];
      arm = poke && (i == 0);
    end
    arm = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, input int nsend, input bit stop_one,
                           input int glitch_idx, input int poke_idx);
    for (int b = 31; b >= 32 - nsend; b--)
      frame((31 - b) == glitch_idx ? F_GLITCH : (w[b] ? F_ONE : F_ZERO), (31 - b) == poke_idx);
    if (nsend == 32) frame(stop_one ? F_ONE : F_ZERO, 1'b0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(data_out == 0, "R1 data after reset", data_out, 0);
    chk(valid == 0, "R1 valid after reset", {31'b0, valid}, 0);
    chk(timeout_err == 0, "R1 err after reset", {31'b0, timeout_err}, 0);

    // R2 R3 R4: table walk
    for (int v = 0; v < NV; v++) begin
      vcnt = 0;
      do_arm();
      send_word(VEC[v], 32, 1'b1, -1, -1);
      chk(data_out == VEC[v], "R2 R3 word decode", data_out, VEC[v]);
      chk(vcnt == 1, "R4 single valid", vcnt, 1);
      chk(timeout_err == 0, "R4 no error", {31'b0, timeout_err}, 0);
    end

    // R5: glitch inside sample window on first bit
    vcnt = 0;
    do_arm();
    send_word(32'hFFFF_FFFF, 32, 1'b1, 0, -1);
    chk(data_out == 32'h7FFF_FFFF, "R5 in-window edge ignored", data_out, 32'h7FFF_FFFF);
    chk(vcnt == 1, "R5 valid count", vcnt, 1);

    // R6: truncated word times out
    vcnt = 0;
    do_arm();
    send_word(32'hDEAD_BEEF, 10, 1'b1, -1, -1);
    repeat (120) @(negedge clk);
    chk(timeout_err == 1, "R6 timeout flag", {31'b0, timeout_err}, 1);
    chk(vcnt == 0, "R6 no valid on abort", vcnt, 0);
    chk(data_out == 32'h7FFF_FFFF, "R6 data kept", data_out, 32'h7FFF_FFFF);

    // R7: arm clears error; arm mid-word ignored
    vcnt = 0;
    do_arm();
    chk(timeout_err == 0, "R7 arm clears error", {31'b0, timeout_err}, 0);
    send_word(32'hC3A5_0F96, 32, 1'b1, -1, 12);
    chk(data_out == 32'hC3A5_0F96, "R7 mid-word arm ignored", data_out, 32'hC3A5_0F96);
    chk(vcnt == 1, "R7 valid count", vcnt, 1);

    // R8: traffic while not armed
    vcnt = 0;
    send_word(32'h0F0F_1234, 32, 1'b1, -1, -1);
    repeat (20) @(negedge clk);
    chk(vcnt == 0, "R8 unarmed no valid", vcnt, 0);
    chk(data_out == 32'hC3A5_0F96, "R8 unarmed data kept", data_out, 32'hC3A5_0F96);

    // R9: stop frame coded as zero
    vcnt = 0;
    do_arm();
    send_word(32'h6B1E_2D74, 32, 1'b0, -1, -1);
    chk(data_out == 32'h6B1E_2D74, "R9 stop value not stored", data_out, 32'h6B1E_2D74);
    chk(vcnt == 1, "R9 valid count", vcnt, 1);

    // R1: reset mid-stream returns outputs to zero
    do_arm();
    frame(F_ONE, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(data_out == 0 && !valid && !timeout_err, "R1 reset clears outputs", data_out, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule